// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block is the power-mode controller of a small processor system. It holds a control register and a control/status register on a plain single-cycle register bus. It turns a core sleep request into one of three low-power modes and drives the matching clock-gate, oscillator, regulator and power-enable outputs. The mode is chosen from a deep-sleep qualifier and one control bit. Without deep sleep the request gives Sleep. With deep sleep it gives Stop, or Standby when the power-down bit is set.

Wakeup sources are three external pins and four event inputs from the real-time clock side: alarm, tamper, timestamp and periodic wakeup. The pins are synchronised, edge-detected and gated by per-pin enables. A sticky wakeup flag and a sticky standby flag are kept. Software clears each one by writing 1 to a control bit two positions above the flag's status bit. The block also carries a write gate for the backup domain and the enable and threshold code for an external supply monitor. The comparators, regulator and oscillators live outside the block and appear only as plain inputs and outputs.

The register bus has no handshake. A write takes effect at the clock edge on which `bus_sel` and `bus_wr` are both high. Read data is combinational from `bus_addr`.

Top module: `lp_mode_ctrl`

## Requirements
- R1: Out of reset `pm_state` is 0 (run), `core_en`, `core_clk_en`, `periph_clk_en`, `osc_en` and `core_pwr_en` are 1, both registers read 0, and `bkp_wr_ok` is 0.
- R2: The control register (address 0) holds these fields: bit 0 regulator low-power in Stop, bit 1 power-down select, bit 4 monitor enable, bits 7:5 monitor level code 0..7, bit 8 backup write enable. They read back as written, bits 2 and 3 read 0, and `bkp_wr_ok` equals `bkp_wr_req` AND bit 8.
- R3: A `sleep_req` with `deep_sleep` low enters Sleep (`pm_state`=1) at the next edge: core clock off, peripheral clock and oscillators on, `core_en` low. With `sleep_on_evt`=0 only `irq_pend` wakes it. With `sleep_on_evt`=1 either `irq_pend` or `evt_pend` wakes it. The return to run (`pm_state`=0) happens at the next edge.
- R4: A `sleep_req` with `deep_sleep` high and control bit 1 clear enters Stop (`pm_state`=2): core clock, peripheral clock and oscillators off, `reg_lowpwr` equal to control bit 0, core power kept on.
- R5: Stop is left on `ext_wake` or any wakeup event. If control bit 0 is set, the controller passes through a restart state (`pm_state`=4) with `core_en` low for exactly STOP_DLY cycles. Otherwise `core_en` is high one cycle after the waking edge.
- R6: `clk_to_rc` is high for exactly one cycle, starting at the edge that leaves Stop, to select the internal RC oscillator as system clock.
- R7: A `sleep_req` with `deep_sleep` high and control bit 1 set enters Standby (`pm_state`=3): core power, all clocks and `core_en` off. A wakeup flag pending at entry is cleared unless a new wakeup event arrives in the same cycle.
- R8: The wakeup pins are enabled by status-register bits 10:8 (pin 0 at bit 8). An enabled pin's rising edge is seen through a two-flop synchroniser and acts at the third clock edge after the pin rises. A disabled pin, or a falling edge, has no effect.
- R9: An enabled pin rising edge, `alarm_evt`, `tamper_evt`, `tstamp_evt` or `periodic_evt` sets the wakeup flag (status bit 0) in any mode, and any of them ends Standby.
- R10: Leaving Standby returns to run, sets the standby flag (status bit 1) and returns the control register to its reset value. The pin enables are kept.
- R11: Writing 1 to control bit 2 clears the wakeup flag, and writing 1 to control bit 3 clears the standby flag. A flag set in the same cycle as its clear wins.
- R12: Status bit 2 reads `supply_below` while the monitor is enabled, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 1 | 0 control, 1 control/status |
| bus_wdata | input | 8+NUM_PINS | Write data |
| bus_rdata | output | 8+NUM_PINS | Read data (combinational) |
| sleep_req | input | 1 | One-cycle core sleep request |
| sleep_on_evt | input | 1 | 1 = wait-for-event, 0 = wait-for-interrupt |
| deep_sleep | input | 1 | Deep-sleep qualifier |
| irq_pend | input | 1 | Enabled interrupt pending |
| evt_pend | input | 1 | Event pending |
| ext_wake | input | 1 | External-line wakeup for Stop |
| wake_pin | input | NUM_PINS | Asynchronous wakeup pins |
| alarm_evt | input | 1 | Alarm wakeup event |
| tamper_evt | input | 1 | Tamper wakeup event |
| tstamp_evt | input | 1 | Timestamp wakeup event |
| periodic_evt | input | 1 | Periodic wakeup event |
| supply_below | input | 1 | Supply monitor comparator output |
| bkp_wr_req | input | 1 | Backup-domain write attempt |
| core_clk_en | output | 1 | Core clock gate |
| periph_clk_en | output | 1 | Peripheral clock gate |
| osc_en | output | 1 | PLL and oscillators enable |
| reg_lowpwr | output | 1 | Regulator low-power mode |
| core_pwr_en | output | 1 | Core-domain power enable |
| core_en | output | 1 | Core release |
| clk_to_rc | output | 1 | Pulse selecting RC clock after Stop |
| mon_en | output | 1 | Supply monitor enable |
| mon_level | output | 3 | Supply monitor threshold code |
| bkp_wen | output | 1 | Backup-domain write enable |
| bkp_wr_ok | output | 1 | Gated backup write |
| pm_state | output | 3 | 0 run, 1 sleep, 2 stop, 3 standby, 4 stop restart |

## Verification
The bound checker watches the output set of every power state on every cycle. Sleep must keep peripheral clocks and core power. Stop must have oscillators and peripheral clocks off. Standby must have power and core release off. The checker also confirms that the RC clock pulse only follows Stop, that the standby flag only rises out of Standby, that a wakeup event always leaves the flag set, and that the backup write gate never opens without its enable. Several things need the bench's scenarios instead. These are the exact restart delay length and the WFI/WFE wake distinction. They also include the synchroniser latency of the pins, the treatment of disabled pins and falling edges, the register reload on Standby exit, and the register field read-back.

// File: rtl/lp_pkg.sv
package lp_pkg;
  typedef enum logic [2:0] {
    PM_RUN       = 3'd0,
    PM_SLEEP     = 3'd1,
    PM_STOP      = 3'd2,
    PM_STANDBY   = 3'd3,
    PM_STOP_EXIT = 3'd4
  } pm_state_e;

  // control register bit positions
  localparam int CB_LPREG = 0;
  localparam int CB_PDOWN = 1;
  localparam int CB_CLRW  = 2;
  localparam int CB_CLRS  = 3;
  localparam int CB_MON   = 4;
  localparam int CB_LVL   = 5;
  localparam int CB_BKP   = 8;
  localparam int LVL_W    = 3;

  // status register bit positions
  localparam int SB_WUF   = 0;
  localparam int SB_SBF   = 1;
  localparam int SB_MON   = 2;
  localparam int PIN_LSB  = 8;

  typedef struct packed {
    logic             bkp_wen;
    logic [LVL_W-1:0] mon_lvl;
    logic             mon_en;
    logic             pdown;
    logic             lp_reg;
  } ctrl_t;
endpackage

// File: rtl/lp_wake_sync.sv
module lp_wake_sync #(
  parameter int NUM_PINS    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins,
  input  logic [NUM_PINS-1:0] pin_en,
  output logic [NUM_PINS-1:0] rise
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [SYNC_STAGES:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[SYNC_STAGES-1:0], pins[i]};
    end
    assign rise[i] = pin_en[i] & sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];
  end
endmodule

// File: rtl/lp_regs.sv
module lp_regs
  import lp_pkg::*;
#(
  parameter int NUM_PINS = 3,
  localparam int DW = PIN_LSB + NUM_PINS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic                bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  input  logic                wake_evt,
  input  logic                stby_enter,
  input  logic                stby_exit,
  input  logic                supply_below,
  output ctrl_t               ctrl,
  output logic [NUM_PINS-1:0] pin_en,
  output logic                wuf,
  output logic                sbf
);
  logic wr_ctrl, wr_stat, clr_w, clr_s;

  assign wr_ctrl = bus_sel & bus_wr & ~bus_addr;
  assign wr_stat = bus_sel & bus_wr &  bus_addr;
  assign clr_w   = wr_ctrl & bus_wdata[CB_CLRW];
  assign clr_s   = wr_ctrl & bus_wdata[CB_CLRS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      pin_en <= '0;
      wuf    <= 1'b0;
      sbf    <= 1'b0;
    end else begin
      if (stby_exit) ctrl <= '0;
      else if (wr_ctrl) begin
        ctrl.lp_reg  <= bus_wdata[CB_LPREG];
        ctrl.pdown   <= bus_wdata[CB_PDOWN];
        ctrl.mon_en  <= bus_wdata[CB_MON];
        ctrl.mon_lvl <= bus_wdata[CB_LVL +: LVL_W];
        ctrl.bkp_wen <= bus_wdata[CB_BKP];
      end
      if (wr_stat) pin_en <= bus_wdata[PIN_LSB +: NUM_PINS];
      if (wake_evt)                 wuf <= 1'b1;
      else if (stby_enter || clr_w) wuf <= 1'b0;
      if (stby_exit)  sbf <= 1'b1;
      else if (clr_s) sbf <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (!bus_addr) begin
      bus_rdata[CB_LPREG]           = ctrl.lp_reg;
      bus_rdata[CB_PDOWN]           = ctrl.pdown;
      bus_rdata[CB_MON]             = ctrl.mon_en;
      bus_rdata[CB_LVL +: LVL_W]    = ctrl.mon_lvl;
      bus_rdata[CB_BKP]             = ctrl.bkp_wen;
    end else begin
      bus_rdata[SB_WUF]             = wuf;
      bus_rdata[SB_SBF]             = sbf;
      bus_rdata[SB_MON]             = supply_below & ctrl.mon_en;
      bus_rdata[PIN_LSB +: NUM_PINS] = pin_en;
    end
  end
endmodule

// File: rtl/lp_seq.sv
module lp_seq
  import lp_pkg::*;
#(
  parameter int STOP_DLY = 8,
  localparam int CW = (STOP_DLY > 1) ? $clog2(STOP_DLY) : 1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sleep_req,
  input  logic      sleep_on_evt,
  input  logic      deep_sleep,
  input  logic      pdown,
  input  logic      lp_reg,
  input  logic      irq_pend,
  input  logic      evt_pend,
  input  logic      stop_wake,
  input  logic      stby_wake,
  output pm_state_e state,
  output logic      stby_enter,
  output logic      stby_exit,
  output logic      clk_to_rc,
  output logic      core_clk_en,
  output logic      periph_clk_en,
  output logic      osc_en,
  output logic      reg_lowpwr,
  output logic      core_pwr_en,
  output logic      core_en
);
  pm_state_e nxt;
  logic          on_evt_q;
  logic [CW-1:0] cnt;

  always_comb begin
    nxt = state;
    unique case (state)
      PM_RUN: if (sleep_req) begin
        if (!deep_sleep) nxt = PM_SLEEP;
        else if (pdown)  nxt = PM_STANDBY;
        else             nxt = PM_STOP;
      end
      PM_SLEEP:     if (irq_pend || (on_evt_q && evt_pend)) nxt = PM_RUN;
      PM_STOP:      if (stop_wake) nxt = lp_reg ? PM_STOP_EXIT : PM_RUN;
      PM_STOP_EXIT: if (cnt == '0) nxt = PM_RUN;
      PM_STANDBY:   if (stby_wake) nxt = PM_RUN;
      default:      nxt = PM_RUN;
    endcase
  end

  assign stby_enter = (state == PM_RUN) && (nxt == PM_STANDBY);
  assign stby_exit  = (state == PM_STANDBY) && (nxt == PM_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= PM_RUN;
      on_evt_q  <= 1'b0;
      cnt       <= '0;
      clk_to_rc <= 1'b0;
    end else begin
      state     <= nxt;
      clk_to_rc <= (state == PM_STOP) && stop_wake;
      if (state == PM_RUN && sleep_req) on_evt_q <= sleep_on_evt;
      if (state == PM_STOP && nxt == PM_STOP_EXIT) cnt <= CW'(STOP_DLY - 1);
      else if (state == PM_STOP_EXIT && cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  always_comb begin
    core_clk_en   = 1'b0;
    periph_clk_en = 1'b0;
    osc_en        = 1'b0;
    reg_lowpwr    = 1'b0;
    core_pwr_en   = 1'b1;
    core_en       = 1'b0;
    unique case (state)
      PM_RUN: begin
        core_clk_en = 1'b1; periph_clk_en = 1'b1; osc_en = 1'b1; core_en = 1'b1;
      end
      PM_SLEEP:     begin periph_clk_en = 1'b1; osc_en = 1'b1; end
      PM_STOP:      reg_lowpwr = lp_reg;
      PM_STOP_EXIT: osc_en = 1'b1;
      PM_STANDBY:   core_pwr_en = 1'b0;
      default: ;
    endcase
  end
endmodule

// File: rtl/lp_mode_ctrl.sv
module lp_mode_ctrl
  import lp_pkg::*;
#(
  parameter int NUM_PINS    = 3,
  parameter int SYNC_STAGES = 2,
  parameter int STOP_DLY    = 8,
  localparam int DW = PIN_LSB + NUM_PINS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic                bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  input  logic                sleep_req,
  input  logic                sleep_on_evt,
  input  logic                deep_sleep,
  input  logic                irq_pend,
  input  logic                evt_pend,
  input  logic                ext_wake,
  input  logic [NUM_PINS-1:0] wake_pin,
  input  logic                alarm_evt,
  input  logic                tamper_evt,
  input  logic                tstamp_evt,
  input  logic                periodic_evt,
  input  logic                supply_below,
  input  logic                bkp_wr_req,
  output logic                core_clk_en,
  output logic                periph_clk_en,
  output logic                osc_en,
  output logic                reg_lowpwr,
  output logic                core_pwr_en,
  output logic                core_en,
  output logic                clk_to_rc,
  output logic                mon_en,
  output logic [LVL_W-1:0]    mon_level,
  output logic                bkp_wen,
  output logic                bkp_wr_ok,
  output logic [2:0]          pm_state
);
  ctrl_t               ctrl;
  logic [NUM_PINS-1:0] pin_en, pin_rise;
  logic                wuf, sbf, wake_src, stby_enter, stby_exit;
  pm_state_e           state;

  lp_wake_sync #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pins(wake_pin), .pin_en(pin_en), .rise(pin_rise)
  );

  assign wake_src = (|pin_rise) | alarm_evt | tamper_evt | tstamp_evt | periodic_evt;

  lp_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wake_evt(wake_src), .stby_enter(stby_enter), .stby_exit(stby_exit),
    .supply_below(supply_below), .ctrl(ctrl), .pin_en(pin_en),
    .wuf(wuf), .sbf(sbf)
  );

  lp_seq #(.STOP_DLY(STOP_DLY)) u_seq (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sleep_on_evt(sleep_on_evt),
    .deep_sleep(deep_sleep), .pdown(ctrl.pdown), .lp_reg(ctrl.lp_reg),
    .irq_pend(irq_pend), .evt_pend(evt_pend),
    .stop_wake(ext_wake | wake_src), .stby_wake(wake_src),
    .state(state), .stby_enter(stby_enter), .stby_exit(stby_exit),
    .clk_to_rc(clk_to_rc), .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en),
    .osc_en(osc_en), .reg_lowpwr(reg_lowpwr), .core_pwr_en(core_pwr_en),
    .core_en(core_en)
  );

  assign pm_state  = state;
  assign mon_en    = ctrl.mon_en;
  assign mon_level = ctrl.mon_lvl;
  assign bkp_wen   = ctrl.bkp_wen;
  assign bkp_wr_ok = bkp_wr_req & ctrl.bkp_wen;
endmodule

// File: rtl/lp_mode_ctrl_chk.sv
module lp_mode_ctrl_chk
  import lp_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] pm_state,
  input logic       core_clk_en,
  input logic       periph_clk_en,
  input logic       osc_en,
  input logic       core_pwr_en,
  input logic       core_en,
  input logic       clk_to_rc,
  input logic       bkp_wen,
  input logic       bkp_wr_ok,
  input logic       wake_flag,
  input logic       stby_flag,
  input logic       wake_src
);
  a_r3_sleep_clocks: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == PM_SLEEP) |-> (periph_clk_en && !core_clk_en && core_pwr_en));

  a_r4_stop_clocks: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == PM_STOP) |-> (!osc_en && !periph_clk_en && core_pwr_en));

  a_r7_standby_off: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == PM_STANDBY) |-> (!core_pwr_en && !core_en && !osc_en));

  a_r5_release_path: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_en) |-> (pm_state == PM_RUN));

  a_r6_rc_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    clk_to_rc |-> ($past(pm_state) == PM_STOP));

  a_r10_sbf_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stby_flag) |-> ($past(pm_state) == PM_STANDBY));

  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wake_src |=> wake_flag);

  a_r2_bkp_gate: assert property (@(posedge clk) disable iff (!rst_n)
    bkp_wr_ok |-> bkp_wen);
endmodule

bind lp_mode_ctrl lp_mode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pm_state(pm_state), .core_clk_en(core_clk_en),
  .periph_clk_en(periph_clk_en), .osc_en(osc_en), .core_pwr_en(core_pwr_en),
  .core_en(core_en), .clk_to_rc(clk_to_rc), .bkp_wen(bkp_wen),
  .bkp_wr_ok(bkp_wr_ok), .wake_flag(wuf), .stby_flag(sbf), .wake_src(wake_src)
);

// File: tb/lp_mode_ctrl_bench.sv
`timescale 1ns/1ps
module lp_mode_ctrl_bench;
  localparam int NP = 3;
  localparam int DW = 8 + NP;
  localparam int DLY = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0, bus_addr = 0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata;
  logic sleep_req = 0, sleep_on_evt = 0, deep_sleep = 0, irq_pend = 0, evt_pend = 0, ext_wake = 0;
  logic [NP-1:0] wake_pin = '0;
  logic alarm_evt = 0, tamper_evt = 0, tstamp_evt = 0, periodic_evt = 0, supply_below = 0, bkp_wr_req = 0;
  logic core_clk_en, periph_clk_en, osc_en, reg_lowpwr, core_pwr_en, core_en, clk_to_rc;
  logic mon_en, bkp_wen, bkp_wr_ok;
  logic [2:0] mon_level, pm_state;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  lp_mode_ctrl #(.NUM_PINS(NP), .SYNC_STAGES(2), .STOP_DLY(DLY)) u_lp_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sleep_req(sleep_req),
    .sleep_on_evt(sleep_on_evt), .deep_sleep(deep_sleep), .irq_pend(irq_pend),
    .evt_pend(evt_pend), .ext_wake(ext_wake), .wake_pin(wake_pin), .alarm_evt(alarm_evt),
    .tamper_evt(tamper_evt), .tstamp_evt(tstamp_evt), .periodic_evt(periodic_evt),
    .supply_below(supply_below), .bkp_wr_req(bkp_wr_req), .core_clk_en(core_clk_en),
    .periph_clk_en(periph_clk_en), .osc_en(osc_en), .reg_lowpwr(reg_lowpwr),
    .core_pwr_en(core_pwr_en), .core_en(core_en), .clk_to_rc(clk_to_rc), .mon_en(mon_en),
    .mon_level(mon_level), .bkp_wen(bkp_wen), .bkp_wr_ok(bkp_wr_ok), .pm_state(pm_state)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic a, input int d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = DW'(d);
    tick();
    bus_sel = 0; bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic rd(input logic a, output int v);
    bus_addr = a; #1; v = int'(bus_rdata);
  endtask

  task automatic request(input logic deep, input logic on_evt);
    sleep_req = 1; deep_sleep = deep; sleep_on_evt = on_evt;
    tick();
    sleep_req = 0; deep_sleep = 0; sleep_on_evt = 0;
  endtask

  task automatic t_reset();
    int v;
    bkp_wr_req = 1; #1;
    check("R1 state", pm_state, 0);
    check("R1 outputs", {core_en, core_clk_en, periph_clk_en, osc_en, core_pwr_en}, 5'b11111);
    check("R1 bkp_wr_ok", bkp_wr_ok, 0);
    rd(0, v); check("R1 ctrl", v, 0);
    rd(1, v); check("R1 status", v, 0);
    bkp_wr_req = 0;
  endtask

  task automatic t_ctrl_fields();
    int v;
    wr(0, 'h1B1);
    rd(0, v); check("R2 readback", v, 'h1B1);
    check("R2 level", mon_level, 5);
    check("R2 mon_en", mon_en, 1);
    bkp_wr_req = 1; #1; check("R2 bkp gate open", bkp_wr_ok, 1); bkp_wr_req = 0;
    supply_below = 1;
    rd(1, v); check("R12 monitor on", v & 4, 4);
    wr(0, 'h00C);
    rd(0, v); check("R2 clear bits read 0", v, 0);
    rd(1, v); check("R12 monitor off", v & 4, 0);
    bkp_wr_req = 1; #1; check("R2 bkp gate closed", bkp_wr_ok, 0); bkp_wr_req = 0;
    supply_below = 0;
  endtask

  task automatic t_sleep_wfi();
    request(0, 0);
    check("R3 sleep state", pm_state, 1);
    check("R3 sleep clocks", {core_clk_en, periph_clk_en, osc_en, core_en}, 4'b0110);
    evt_pend = 1; tick(); evt_pend = 0;
    check("R3 wfi ignores event", pm_state, 1);
    irq_pend = 1; tick(); irq_pend = 0;
    check("R3 wfi irq wake", pm_state, 0);
    check("R3 core released", core_en, 1);
  endtask

  task automatic t_sleep_wfe();
    request(0, 1);
    check("R3 wfe sleep", pm_state, 1);
    evt_pend = 1; tick(); evt_pend = 0;
    check("R3 wfe event wake", pm_state, 0);
  endtask

  task automatic t_stop_lp();
    wr(0, 'h001);
    request(1, 0);
    check("R4 stop state", pm_state, 2);
    check("R4 stop outputs", {core_clk_en, periph_clk_en, osc_en, reg_lowpwr, core_pwr_en}, 5'b00011);
    ext_wake = 1; tick(); ext_wake = 0;
    check("R5 restart state", pm_state, 4);
    check("R6 rc pulse", clk_to_rc, 1);
    for (int i = 1; i < DLY; i++) begin
      tick();
      check("R5 core held", core_en, 0);
      if (i == 1) check("R6 pulse one cycle", clk_to_rc, 0);
    end
    tick();
    check("R5 core after delay", core_en, 1);
  endtask

  task automatic t_stop_reg_on();
    wr(0, 'h000);
    request(1, 0);
    check("R4 regulator on in stop", reg_lowpwr, 0);
    ext_wake = 1; tick(); ext_wake = 0;
    check("R5 no delay", core_en, 1);
    check("R6 rc pulse fast exit", clk_to_rc, 1);
    tick();
    check("R6 pulse ended", clk_to_rc, 0);
  endtask

  task automatic t_standby_pin();
    int v;
    wr(1, 'h100);
    alarm_evt = 1; tick(); alarm_evt = 0;
    rd(1, v); check("R9 alarm sets flag", v & 1, 1);
    wr(0, 'h102);
    request(1, 0);
    check("R7 standby state", pm_state, 3);
    check("R7 standby off", {core_pwr_en, core_en, osc_en, core_clk_en}, 0);
    rd(1, v); check("R7 flag cleared on entry", v & 1, 0);
    wake_pin[1] = 1;
    for (int i = 0; i < 5; i++) tick();
    check("R8 disabled pin ignored", pm_state, 3);
    wake_pin[1] = 0;
    wake_pin[0] = 1; tick(); tick();
    check("R8 sync latency", pm_state, 3);
    tick();
    check("R9 pin wakes standby", pm_state, 0);
    rd(1, v); check("R10 flags and enables", v, 'h103);
    rd(0, v); check("R10 ctrl reset", v, 0);
    wake_pin[0] = 0;
    for (int i = 0; i < 4; i++) tick();
    rd(1, v); check("R8 falling edge no flag change", v & 3, 3);
  endtask

  task automatic t_flag_clear();
    int v;
    wr(0, 'h00C);
    rd(1, v); check("R11 both cleared", v & 3, 0);
    wake_pin[0] = 1; tick(); tick(); tick();
    rd(1, v); check("R8 run-mode pin edge", v & 1, 1);
    wake_pin[0] = 0;
    tstamp_evt = 1; wr(0, 'h004); tstamp_evt = 0;
    rd(1, v); check("R11 set wins", v & 1, 1);
    wr(0, 'h004);
    rd(1, v); check("R11 clear wuf", v & 1, 0);
    periodic_evt = 1; tick(); periodic_evt = 0;
    rd(1, v); check("R9 periodic sets flag", v & 1, 1);
  endtask

  task automatic t_standby_rtc();
    int v;
    wr(0, 'h00E);
    request(1, 0);
    check("R7 standby again", pm_state, 3);
    tamper_evt = 1; tick(); tamper_evt = 0;
    check("R9 tamper wakes", pm_state, 0);
    rd(1, v); check("R10 standby flag", v & 2, 2);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    t_reset();
    t_ctrl_fields();
    t_sleep_wfi();
    t_sleep_wfe();
    t_stop_lp();
    t_stop_reg_on();
    t_standby_pin();
    t_flag_clear();
    t_standby_rtc();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule